// File: doc/BRIEF.md
# ACPI Sleep Control Register

This block holds one 32-bit power-management control word. The word sits on a simple I/O register bus with an address, write data, a write strobe and a combinational read-data return. It stores a 3-bit sleep-type code, a bus-master break enable and an interrupt-routing select. A write that sets the sleep-enable trigger bit starts the sleep state named by the type code. That state drives a set of registered sleep outputs: a processor stop-clock line and the S3, S4 and S5 suspend lines. The outputs hold until a wake input returns them to the working state.

A second write-only bit raises a one-cycle release event toward firmware. A pending power-management event input goes to either the SCI or the SMI output, depending on the routing select. The reset is split into two domains. The always-on real-time reset clears the sleep-type code and the sleep outputs. The platform reset clears the bus-master enable and the routing select.

Top module: `acpi_sleep_ctl`

## Requirements
- R1: After both resets, the word at the control offset (04h) reads 00000000h, and all sleep outputs, the release pulse, SCI and SMI are low.
- R2: A write at offset 04h stores data bits 12:10 as the sleep type, bit 1 as the bus-master break enable and bit 0 as the routing select. A read at 04h returns exactly those bits in place. Bits 13 and 2 and every other bit read 0.
- R3: A write strobe at any other address changes nothing. A read at any other address returns 0.
- R4: A write at 04h with bit 13 = 1 and type 001 drives only the stop-clock output high, starting the cycle after the write. With type 000 it drives all sleep outputs low.
- R5: With bit 13 = 1, type 101 drives S3 only, type 110 drives S3 and S4, and type 111 drives S3, S4 and S5. The outputs change the cycle after the write, and the stop-clock output is low in each case.
- R6: With bit 13 = 1 and a reserved type (010, 011 or 100), the sleep outputs keep their previous values. The type field is still written.
- R7: The sleep outputs hold until the wake input is sampled high. The wake input clears them on the next edge, takes priority over a sleep write in the same cycle, and leaves the stored type unchanged.
- R8: The release output is high in exactly the cycle of an accepted write at 04h whose bit 2 is 1, and low otherwise.
- R9: While the event input is high, SCI is high when the routing select is 1 and SMI is high when it is 0. Both are low when the event input is low.
- R10: The C3 break output is high only while the bus-master break enable is 1 and the bus-master request input is high.
- R11: The platform reset clears bits 1 and 0 but keeps the sleep type and the sleep outputs. The real-time reset clears the sleep type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Always-on domain reset, active low |
| plt_rst_n | input | 1 | Platform domain reset, active low |
| io_addr | input | ADDR_W | Register bus address |
| io_wdata | input | DATA_W | Register bus write data |
| io_we | input | 1 | Write strobe |
| io_rdata | output | DATA_W | Read data for the current address |
| wake | input | 1 | Returns the sleep outputs to the working state |
| pm_evt | input | 1 | Pending power-management event |
| bm_req | input | 1 | Bus-master activity |
| stpclk_o | output | 1 | Processor stop-clock request |
| slp_s3_o | output | 1 | S3 suspend line |
| slp_s4_o | output | 1 | S4 suspend line |
| slp_s5_o | output | 1 | S5 suspend line |
| fw_rel_o | output | 1 | One-cycle release event to firmware |
| sci_o | output | 1 | Event routed as SCI |
| smi_o | output | 1 | Event routed as SMI |
| c3_brk_o | output | 1 | Bus-master break from C3 |

## Verification
The assertions check several properties on every cycle. The suspend lines always nest (S5 implies S4, S4 implies S3), and stop-clock never appears together with them. SCI and SMI are never high together. Bits 13 and 2 always read 0. A wake always clears the outputs on the next edge, and the outputs stay stable when neither a wake nor a sleep write occurs. Only the bench scenarios can show the other behaviours: the exact output set for each type code, that reserved codes are ignored while the field is still written, that each reset domain keeps what it should, and the read-back of stored fields.

// File: rtl/acpi_sleep_pkg.sv
`timescale 1ns/1ps
package acpi_sleep_pkg;

   localparam int TYP_W      = 3;
   localparam int TYP_LO     = 10;
   localparam int SLP_GO_BIT = 13;
   localparam int REL_BIT    = 2;
   localparam int BMB_BIT    = 1;
   localparam int ROUTE_BIT  = 0;
   localparam int MIN_DATA_W = SLP_GO_BIT + 1;

   typedef struct packed {
      logic stpclk;
      logic s3;
      logic s4;
      logic s5;
   } slp_outs_t;

   localparam slp_outs_t OUTS_IDLE = '{stpclk: 1'b0, s3: 1'b0, s4: 1'b0, s5: 1'b0};

   // codes 010, 011, 100 carry no sleep state
   function automatic logic typ_is_valid(input logic [TYP_W-1:0] t);
      return !((t == 3'b010) || (t == 3'b011) || (t == 3'b100));
   endfunction

   function automatic slp_outs_t typ_to_outs(input logic [TYP_W-1:0] t);
      slp_outs_t o;
      o        = OUTS_IDLE;
      o.stpclk = (t == 3'b001);
      o.s3     = t[2] & (t[1] | t[0]);
      o.s4     = t[2] & t[1];
      o.s5     = &t;
      return o;
   endfunction

endpackage

// File: rtl/asc_regfile.sv
`timescale 1ns/1ps
module asc_regfile #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rtc_rst_n,
   input  logic              plt_rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rtc_word,
   output logic [DATA_W-1:0] plt_word
);
   import acpi_sleep_pkg::*;

   localparam logic [DATA_W-1:0] RTC_MASK = {{(DATA_W-TYP_W){1'b0}}, {TYP_W{1'b1}}} << TYP_LO;
   localparam logic [DATA_W-1:0] PLT_MASK = (DATA_W'(1) << BMB_BIT) | (DATA_W'(1) << ROUTE_BIT);

   logic [DATA_W-1:0] rtc_q;
   logic [DATA_W-1:0] plt_q;

   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n)  rtc_q <= '0;
      else if (wr_hit) rtc_q <= wdata & RTC_MASK;
   end

   always_ff @(posedge clk or negedge plt_rst_n) begin
      if (!plt_rst_n)  plt_q <= '0;
      else if (wr_hit) plt_q <= wdata & PLT_MASK;
   end

   assign rtc_word = rtc_q;
   assign plt_word = plt_q;

endmodule

// File: rtl/asc_sleep_seq.sv
`timescale 1ns/1ps
module asc_sleep_seq
   import acpi_sleep_pkg::*;
(
   input  logic             clk,
   input  logic             rtc_rst_n,
   input  logic             go,
   input  logic [TYP_W-1:0] req_typ,
   input  logic             wake,
   output slp_outs_t        outs
);

   slp_outs_t outs_q;
   slp_outs_t outs_d;

   always_comb begin
      outs_d = outs_q;
      if (wake)                               outs_d = OUTS_IDLE;
      else if (go && typ_is_valid(req_typ))   outs_d = typ_to_outs(req_typ);
   end

   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) outs_q <= OUTS_IDLE;
      else            outs_q <= outs_d;
   end

   assign outs = outs_q;

endmodule

// File: rtl/asc_evt_route.sv
`timescale 1ns/1ps
module asc_evt_route #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic plt_rst_n,
   input  logic route_sci,
   input  logic bm_brk_en,
   input  logic pm_evt,
   input  logic bm_req,
   output logic sci_o,
   output logic smi_o,
   output logic c3_brk_o
);

   logic sci_d, smi_d, brk_d;

   assign sci_d = pm_evt &  route_sci;
   assign smi_d = pm_evt & ~route_sci;
   assign brk_d = bm_req &  bm_brk_en;

   generate
      if (REG_OUT) begin : g_reg
         logic sci_q, smi_q, brk_q;
         always_ff @(posedge clk or negedge plt_rst_n) begin
            if (!plt_rst_n) begin
               sci_q <= 1'b0;
               smi_q <= 1'b0;
               brk_q <= 1'b0;
            end else begin
               sci_q <= sci_d;
               smi_q <= smi_d;
               brk_q <= brk_d;
            end
         end
         assign sci_o    = sci_q;
         assign smi_o    = smi_q;
         assign c3_brk_o = brk_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ plt_rst_n;
         assign sci_o      = sci_d;
         assign smi_o      = smi_d;
         assign c3_brk_o   = brk_d;
      end
   endgenerate

endmodule

// File: rtl/acpi_sleep_ctl.sv
`timescale 1ns/1ps
module acpi_sleep_ctl #(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 32,
   parameter logic [ADDR_W-1:0] CTL_OFS = 8'h04,
   parameter bit              REG_ROUTE = 1'b0
) (
   input  logic              clk,
   input  logic              rtc_rst_n,
   input  logic              plt_rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_we,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              wake,
   input  logic              pm_evt,
   input  logic              bm_req,
   output logic              stpclk_o,
   output logic              slp_s3_o,
   output logic              slp_s4_o,
   output logic              slp_s5_o,
   output logic              fw_rel_o,
   output logic              sci_o,
   output logic              smi_o,
   output logic              c3_brk_o
);
   import acpi_sleep_pkg::*;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_w
         $error("acpi_sleep_ctl: DATA_W too small for the control fields");
      end
      if (ADDR_W < 3) begin : g_bad_a
         $error("acpi_sleep_ctl: ADDR_W cannot hold the control offset");
      end
   endgenerate

   logic              addr_hit;
   logic              wr_hit;
   logic [DATA_W-1:0] rtc_word;
   logic [DATA_W-1:0] plt_word;
   slp_outs_t         outs;

   assign addr_hit = (io_addr == CTL_OFS);
   assign wr_hit   = io_we & addr_hit;

   asc_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rtc_rst_n(rtc_rst_n),
      .plt_rst_n(plt_rst_n),
      .wr_hit   (wr_hit),
      .wdata    (io_wdata),
      .rtc_word (rtc_word),
      .plt_word (plt_word)
   );

   asc_sleep_seq u_seq (
      .clk      (clk),
      .rtc_rst_n(rtc_rst_n),
      .go       (wr_hit & io_wdata[SLP_GO_BIT]),
      .req_typ  (io_wdata[TYP_LO +: TYP_W]),
      .wake     (wake),
      .outs     (outs)
   );

   asc_evt_route #(.REG_OUT(REG_ROUTE)) u_route (
      .clk      (clk),
      .plt_rst_n(plt_rst_n),
      .route_sci(plt_word[ROUTE_BIT]),
      .bm_brk_en(plt_word[BMB_BIT]),
      .pm_evt   (pm_evt),
      .bm_req   (bm_req),
      .sci_o    (sci_o),
      .smi_o    (smi_o),
      .c3_brk_o (c3_brk_o)
   );

   assign io_rdata = addr_hit ? (rtc_word | plt_word) : '0;
   assign fw_rel_o = wr_hit & io_wdata[REL_BIT];
   assign stpclk_o = outs.stpclk;
   assign slp_s3_o = outs.s3;
   assign slp_s4_o = outs.s4;
   assign slp_s5_o = outs.s5;

endmodule

// File: rtl/asc_chk.sv
`timescale 1ns/1ps
module asc_chk #(
   parameter int              ADDR_W  = 8,
   parameter int              DATA_W  = 32,
   parameter logic [ADDR_W-1:0] CTL_OFS = 8'h04
) (
   input logic              clk,
   input logic              rtc_rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_we,
   input logic [DATA_W-1:0] io_rdata,
   input logic              wake,
   input logic              stpclk_o,
   input logic              slp_s3_o,
   input logic              slp_s4_o,
   input logic              slp_s5_o,
   input logic              sci_o,
   input logic              smi_o
);

   logic go_seen;
   logic any_slp;
   assign go_seen = io_we && (io_addr == CTL_OFS) && io_wdata[13];
   assign any_slp = stpclk_o | slp_s3_o | slp_s4_o | slp_s5_o;

   // R5
   s5_needs_s4_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      slp_s5_o |-> slp_s4_o);
   // R5
   s4_needs_s3_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      slp_s4_o |-> slp_s3_o);
   // R4
   stpclk_alone_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      stpclk_o |-> !slp_s3_o);
   // R7
   wake_clears_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      wake |=> !any_slp);
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (!wake && !go_seen) |=> $stable({stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o}));
   // R9
   route_excl_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !(sci_o && smi_o));
   // R2
   wo_bits_zero_chk: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (io_rdata[13] == 1'b0) && (io_rdata[2] == 1'b0));

endmodule

bind acpi_sleep_ctl asc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_OFS(CTL_OFS)) u_chk (
   .clk(clk), .rtc_rst_n(rtc_rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
   .io_we(io_we), .io_rdata(io_rdata), .wake(wake), .stpclk_o(stpclk_o),
   .slp_s3_o(slp_s3_o), .slp_s4_o(slp_s4_o), .slp_s5_o(slp_s5_o),
   .sci_o(sci_o), .smi_o(smi_o)
);

// File: tb/acpi_sleep_ctl_tb.sv
`timescale 1ns/1ps
module acpi_sleep_ctl_tb;

   logic        clk = 1'b0;
   logic        rtc_rst_n = 1'b0, plt_rst_n = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [31:0] io_wdata = '0;
   logic        io_we = 1'b0, wake = 1'b0, pm_evt = 1'b0, bm_req = 1'b0;
   logic [31:0] io_rdata;
   logic stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o, fw_rel_o, sci_o, smi_o, c3_brk_o;

   int vecs = 0, errs = 0;

   // model state
   logic [2:0] m_typ = '0;
   logic       m_bm = 1'b0, m_sci = 1'b0;
   logic [3:0] m_outs = '0; // {stpclk,s3,s4,s5}

   always #4 clk = ~clk;

   acpi_sleep_ctl u_dut (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .plt_rst_n(plt_rst_n),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we), .io_rdata(io_rdata),
      .wake(wake), .pm_evt(pm_evt), .bm_req(bm_req),
      .stpclk_o(stpclk_o), .slp_s3_o(slp_s3_o), .slp_s4_o(slp_s4_o), .slp_s5_o(slp_s5_o),
      .fw_rel_o(fw_rel_o), .sci_o(sci_o), .smi_o(smi_o), .c3_brk_o(c3_brk_o)
   );

   function automatic logic [3:0] exp_outs(input logic [2:0] t, input logic [3:0] prev);
      case (t)
         3'b000:  return 4'b0000;
         3'b001:  return 4'b1000;
         3'b101:  return 4'b0100;
         3'b110:  return 4'b0110;
         3'b111:  return 4'b0111;
         default: return prev;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      return (a == 8'h04) ? {19'd0, m_typ, 8'd0, m_bm, m_sci} : 32'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, check combinational results, then advance and update model
   task automatic step(input logic [7:0] a, input logic [31:0] d, input logic we,
                       input logic wk, input logic ev, input logic bq, input string tag);
      logic hit;
      io_addr = a; io_wdata = d; io_we = we; wake = wk; pm_evt = ev; bm_req = bq;
      #1;
      hit = we && (a == 8'h04);
      chk({tag, " R8 release"}, {31'd0, fw_rel_o}, {31'd0, hit & d[2]});
      chk({tag, " R9 sci/smi"}, {30'd0, sci_o, smi_o}, {30'd0, ev & m_sci, ev & ~m_sci});
      chk({tag, " R10 c3 break"}, {31'd0, c3_brk_o}, {31'd0, bq & m_bm});
      chk({tag, " R2/R3 read"}, io_rdata, exp_read(a));
      @(posedge clk);
      if (wk)                m_outs = 4'b0000;
      else if (hit && d[13]) m_outs = exp_outs(d[12:10], m_outs);
      if (hit) begin
         m_typ = d[12:10]; m_bm = d[1]; m_sci = d[0];
      end
      @(negedge clk);
      chk({tag, " R4/R5/R6/R7 outs"}, {28'd0, stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o},
          {28'd0, m_outs});
   endtask

   task automatic wr(input logic [31:0] d, input string tag);
      step(8'h04, d, 1'b1, 1'b0, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      int seed;
      logic [2:0] rt;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (2) @(negedge clk);
      rtc_rst_n = 1'b1; plt_rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      io_addr = 8'h04; #1;
      chk("R1 read after reset", io_rdata, 32'd0);
      chk("R1 outputs after reset", {24'd0, stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o,
          fw_rel_o, sci_o, smi_o, c3_brk_o}, 32'd0);

      // R2 all-ones write: fields stored, WO and reserved read 0; type 111 sleeps
      wr(32'hFFFF_FFFF, "R2 ones");
      chk("R2 readback", exp_read(8'h04), 32'h0000_1C03);
      step(8'h04, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 read");
      chk("R5 type111", {28'd0, stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o}, 32'h7);
      // R7 wake clears, type kept
      step(8'h10, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 wake");
      chk("R7 type kept", {29'd0, m_typ}, 32'd7);
      // R4 light sleep then working
      wr(32'h0000_2400, "R4 t001");
      wr(32'h0000_2000, "R4 t000");
      // R5 each suspend type
      wr(32'h0000_3400, "R5 t101");
      wr(32'h0000_3800, "R5 t110");
      // R6 reserved types keep outputs
      wr(32'h0000_2800, "R6 t010");
      wr(32'h0000_2C00, "R6 t011");
      wr(32'h0000_3000, "R6 t100");
      // R7 wake beats simultaneous sleep write
      step(8'h04, 32'h0000_3C00, 1'b1, 1'b1, 1'b0, 1'b0, "R7 wake prio");
      // R3 write elsewhere ignored
      step(8'h05, 32'h0000_3C03, 1'b1, 1'b0, 1'b1, 1'b1, "R3 miss");
      // R8 release bit alone, R9 sci route
      wr(32'h0000_0007 | 32'h0000_1400, "R8 rel");
      step(8'h04, 0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 sci");

      // R11 platform reset keeps type and outputs
      wr(32'h0000_3403, "R11 setup");
      plt_rst_n = 1'b0; #1;
      m_bm = 1'b0; m_sci = 1'b0;
      chk("R11 plt reset read", io_rdata, 32'h0000_1400);
      @(posedge clk); @(negedge clk);
      plt_rst_n = 1'b1;
      chk("R11 outputs kept", {28'd0, stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o}, 32'h4);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = ($urandom % 4 != 0) ? 8'h04 : 8'($urandom);
         d = $urandom;
         rt = 3'($urandom);
         d[12:10] = rt;
         d[13] = ($urandom % 3 == 0);
         step(a, d, ($urandom % 2 == 0), ($urandom % 10 == 0),
              1'($urandom), 1'($urandom), "rand");
      end

      // R11 real-time reset clears type
      rtc_rst_n = 1'b0; plt_rst_n = 1'b0; #1;
      m_typ = '0; m_bm = 1'b0; m_sci = 1'b0; m_outs = '0;
      io_addr = 8'h04; #1;
      chk("R11 rtc reset read", io_rdata, 32'd0);
      chk("R1 rtc reset outs", {28'd0, stpclk_o, slp_s3_o, slp_s4_o, slp_s5_o}, 32'd0);
      @(negedge clk);
      rtc_rst_n = 1'b1; plt_rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule